// File: doc/BRIEF.md
# Quarter-Wave Sine Lookup Converter

This block turns a truncated phase word into a signed sine amplitude. It sits after the phase accumulator of a synthesizer. It takes the upper bits of the accumulator as an address and returns one sample of a single full sine period per phase code. Only the first quarter of the period is held in a table. The two top phase bits name the quadrant. From them the block reverses the table address on the descending quarters and negates the value on the negative half-cycle.

Every table entry is computed while the design elaborates. Entry `k` of a quarter holding `2^(P-2)` points is the value of `sin((k + 0.5) * (pi/2) / 2^(P-2))`, scaled to the largest positive code and rounded to the nearest integer. Because of the half-step offset, no entry falls on zero or on the peak. Because the scale stops one step below the signed limit, a negated value always fits.

Results come out with a fixed two-cycle latency, each marked by a valid strobe. A new phase word may be accepted on every clock.

Top module: `sine_quarter_lut`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `amp_valid_o` is 0 and `amp_o` is 0 after that edge.
- R2: `amp_valid_o` is high exactly two rising edges after each edge at which `phase_valid_i` is high, and low two edges after each edge at which it is low.
- R3: For a phase code whose top two bits are 00 and whose remaining Q = PHASE_W-2 bits hold `k`, the output is `round(FS * sin((k + 0.5) * pi / 2 / 2^Q))`, where FS = 2^(AMP_W-1) - 1.
- R4: For top bits 01 and lower bits `j`, the output equals the R3 value for index `2^Q - 1 - j`, so the second quarter retraces the first in reverse.
- R5: For top bits 10 and 11, the output is the two's-complement negation of the output for the same code with the top bit cleared.
- R6: A valid output never equals the most negative code -2^(AMP_W-1), and its magnitude never exceeds FS.
- R7: While `phase_valid_i` is low, `phase_i` has no effect: two edges later `amp_o` still holds the last valid result.
- R8: Phase words presented on consecutive cycles each produce their own correct result on consecutive cycles, with no gap.
- R9: A valid output is greater than or equal to 0 when the phase top bit was 0, and less than or equal to 0 when it was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_valid_i | input | 1 | Marks `phase_i` as a word to convert |
| phase_i | input | PHASE_W | Truncated phase word; the top two bits give the quadrant |
| amp_valid_o | output | 1 | Marks `amp_o` as a fresh result |
| amp_o | output | AMP_W | Signed sine amplitude in two's complement |

## Verification
The bench streams every phase code in ascending order with no gaps. The first quarter checks the rounding of the table. The second quarter separates a correct reversed address from one that is off by one or not reversed at all. The two lower quarters separate correct negation from bit inversion or a missing sign. Targeted pairs then compare mirror codes with each other, and each code with its half-period partner, through isolated single conversions. Those runs also show whether the valid strobe lands on the second edge rather than the first or the third. Idle stretches in which the phase word keeps changing, and a reset asserted in the middle of a stream, show whether results are held and cleared correctly.

// File: rtl/sine_lut_pkg.sv
// Shared definitions for the quarter-wave sine converter.
// Provides the quadrant encoding and the elaboration-time function that
// computes one entry of the stored quarter wave.
package sine_lut_pkg;

    // Quadrant named by the two top phase bits; the order is behavioural.
    typedef enum logic [1:0] {
        QD_RISE  = 2'b00,   // 0..90 degrees, table read forward
        QD_FALL  = 2'b01,   // 90..180 degrees, table read in reverse
        QD_DROP  = 2'b10,   // 180..270 degrees, forward and negated
        QD_CLIMB = 2'b11    // 270..360 degrees, reverse and negated
    } quadrant_e;

    localparam real HALF_PI = 1.5707963267948966;

    // Rounded magnitude of entry idx in a quarter of 2**addr_bits points,
    // scaled to the largest positive code of an amp_bits signed word.
    function automatic int quarter_sample(input int idx, input int addr_bits,
                                          input int amp_bits);
        real full_scale;
        real angle;
        full_scale = real'((1 << (amp_bits - 1)) - 1);
        angle      = (real'(idx) + 0.5) * HALF_PI / real'(1 << addr_bits);
        return $rtoi(full_scale * $sin(angle) + 0.5);
    endfunction

endpackage

// File: rtl/quad_addr_map.sv
// Quadrant decoder and address folder (combinational).
// Splits the phase word into a quarter-table address and a negate flag.
// Assumes PHASE_W >= 3, so that at least one address bit remains.
module quad_addr_map
    import sine_lut_pkg::*;
#(
    parameter int PHASE_W = 12,
    localparam int ADDR_W = PHASE_W - 2
) (
    input  logic [PHASE_W-1:0] phase_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               negate_o
);

    quadrant_e         quad;
    logic [ADDR_W-1:0] low_bits;

    // Fold the address on the descending quarters; flag the negative half.
    always_comb begin
        quad     = quadrant_e'(phase_i[PHASE_W-1 -: 2]);
        low_bits = phase_i[ADDR_W-1:0];
        unique case (quad)
            QD_RISE, QD_DROP:  addr_o = low_bits;
            QD_FALL, QD_CLIMB: addr_o = ~low_bits;
            default:           addr_o = low_bits;
        endcase
        negate_o = (quad == QD_DROP) || (quad == QD_CLIMB);
    end

endmodule

// File: rtl/quarter_rom.sv
// Quarter-wave magnitude table with a registered read port.
// The entries are built at elaboration from sine_lut_pkg::quarter_sample.
// The output register loads only when rd_en is high and otherwise holds.
module quarter_rom
    import sine_lut_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int MAG_W  = 15,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MAG_W-1:0]  mag_o
);

    logic [MAG_W-1:0] table_w [DEPTH];

    // One constant entry per table index.
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign table_w[k] = MAG_W'(quarter_sample(k, ADDR_W, MAG_W + 1));
    end

    // Registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_o <= '0;
        end else if (rd_en) begin
            mag_o <= table_w[addr_i];
        end
    end

endmodule

// File: rtl/sign_restore.sv
// Output stage: attaches the sign of the half-cycle to the magnitude and
// registers the result together with its valid flag.
// Assumes the magnitude never exceeds 2**MAG_W - 1, so negation fits.
module sign_restore #(
    parameter int MAG_W  = 15,
    localparam int AMP_W = MAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic                    neg_i,
    input  logic [MAG_W-1:0]        mag_i,
    output logic                    vld_o,
    output logic signed [AMP_W-1:0] amp_o
);

    logic signed [AMP_W-1:0] pos_val;
    logic signed [AMP_W-1:0] most_neg;

    // Magnitude widened to a non-negative signed word.
    always_comb begin
        pos_val  = $signed({1'b0, mag_i});
        most_neg = $signed({1'b1, {MAG_W{1'b0}}});
    end

    // Register the signed result; hold it when no new sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            amp_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                amp_o <= neg_i ? -pos_val : pos_val;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (amp_o != most_neg)); // R6

    AST_NEG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && neg_i) |=> (amp_o <= 0)); // R9

endmodule

// File: rtl/sine_quarter_lut.sv
// Quarter-wave sine lookup converter (top).
// Stage 0 folds the phase into a table address and a sign.
// Stage 1 reads the table and carries the valid and sign flags along.
// Stage 2 applies the sign. The fixed latency is two cycles.
// Assumes the phase word is already truncated to PHASE_W bits.
module sine_quarter_lut #(
    parameter int PHASE_W = 12,
    parameter int AMP_W   = 16,
    localparam int ADDR_W = PHASE_W - 2,
    localparam int MAG_W  = AMP_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phase_valid_i,
    input  logic [PHASE_W-1:0]      phase_i,
    output logic                    amp_valid_o,
    output logic signed [AMP_W-1:0] amp_o
);

    logic [ADDR_W-1:0] rom_addr;
    logic              negate_c;
    logic [MAG_W-1:0]  rom_mag;
    logic              vld1_q;
    logic              neg1_q;

    quad_addr_map #(.PHASE_W(PHASE_W)) u_map (
        .phase_i  (phase_i),
        .addr_o   (rom_addr),
        .negate_o (negate_c)
    );

    quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (phase_valid_i),
        .addr_i (rom_addr),
        .mag_o  (rom_mag)
    );

    // Stage-1 flags that travel beside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1_q <= 1'b0;
            neg1_q <= 1'b0;
        end else begin
            vld1_q <= phase_valid_i;
            if (phase_valid_i) begin
                neg1_q <= negate_c;
            end
        end
    end

    sign_restore #(.MAG_W(MAG_W)) u_sign (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vld1_q),
        .neg_i (neg1_q),
        .mag_i (rom_mag),
        .vld_o (amp_valid_o),
        .amp_o (amp_o)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid_i |-> ##2 amp_valid_o); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_valid_i |-> ##2 !amp_valid_o); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_valid_i |-> ##2 $stable(amp_o)); // R7

    AST_POS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid_i && !phase_i[PHASE_W-1]) |-> ##2 (amp_o >= 0)); // R9

    AST_NEG_HALF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid_i && phase_i[PHASE_W-1]) |-> ##2 (amp_o <= 0)); // R9

endmodule

// File: tb/sine_quarter_lut_bench.sv
// Directed bench for sine_quarter_lut: one task per scenario.
module sine_quarter_lut_bench;

    localparam int P     = 12;
    localparam int A     = 16;
    localparam int QW    = P - 2;
    localparam int DEPTH = 1 << QW;
    localparam int FS    = (1 << (A - 1)) - 1;
    localparam int MOSTN = -(1 << (A - 1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                phase_valid_i = 1'b0;
    logic [P-1:0]        phase_i = '0;
    logic                amp_valid_o;
    logic signed [A-1:0] amp_o;

    int n_checks = 0;
    int n_fails  = 0;

    // History of the two most recent stream inputs: [0] newest.
    logic   hv [2];
    int     hx [2];

    sine_quarter_lut #(.PHASE_W(P), .AMP_W(A)) u_sine_quarter_lut (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_valid_i (phase_valid_i),
        .phase_i       (phase_i),
        .amp_valid_o   (amp_valid_o),
        .amp_o         (amp_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Expected amplitude from the requirements R3, R4, R5.
    function automatic int ref_amp(input int code);
        int  q;
        int  low;
        int  idx;
        int  m;
        real ang;
        q    = code >> QW;
        low  = code & (DEPTH - 1);
        idx  = (q % 2 == 1) ? (DEPTH - 1 - low) : low;
        ang  = (real'(idx) + 0.5) * (3.141592653589793 / 2.0) / real'(DEPTH);
        m    = $rtoi(real'(FS) * $sin(ang) + 0.5);
        return (q >= 2) ? -m : m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // One stream cycle, called at a negedge: check the result of the input
    // from two negedges ago, then drive the new input.
    task automatic step(input logic v, input int code);
        string tag;
        int    exp_v;
        if (hv[1]) begin
            exp_v = ref_amp(hx[1]);
            case (hx[1] >> QW)
                0:       tag = "R3";
                1:       tag = "R4";
                default: tag = "R5";
            endcase
            chk(amp_valid_o == 1'b1, "R2 R8 valid", int'(amp_valid_o), 1);
            chk(int'(amp_o) == exp_v, tag, int'(amp_o), exp_v);
            chk(int'(amp_o) != MOSTN && int'(amp_o) <= FS && int'(amp_o) >= -FS,
                "R6", int'(amp_o), exp_v);
            if (hx[1] >= (1 << (P - 1))) chk(amp_o <= 0, "R9 negative half", int'(amp_o), exp_v);
            else                         chk(amp_o >= 0, "R9 positive half", int'(amp_o), exp_v);
        end else begin
            chk(amp_valid_o == 1'b0, "R2 idle", int'(amp_valid_o), 0);
        end
        hv[1] = hv[0];
        hx[1] = hx[0];
        hv[0] = v;
        hx[0] = code;
        phase_valid_i = v;
        phase_i       = P'(code);
        @(negedge clk);
    endtask

    // Isolated conversion; also checks that valid rises on the second edge.
    task automatic single(input int code, output int result);
        phase_valid_i = 1'b1;
        phase_i       = P'(code);
        @(negedge clk);
        phase_valid_i = 1'b0;
        phase_i       = ~phase_i;
        chk(amp_valid_o == 1'b0, "R2 not after one edge", int'(amp_valid_o), 0);
        @(negedge clk);
        chk(amp_valid_o == 1'b1, "R2 after two edges", int'(amp_valid_o), 1);
        result = int'(amp_o);
        @(negedge clk);
        chk(amp_valid_o == 1'b0, "R2 single pulse", int'(amp_valid_o), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        phase_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(amp_valid_o == 1'b0, "R1 valid in reset", int'(amp_valid_o), 0);
        chk(int'(amp_o) == 0, "R1 amp in reset", int'(amp_o), 0);
        rst_n = 1'b1;
        hv[0] = 1'b0; hv[1] = 1'b0; hx[0] = 0; hx[1] = 0;
        @(negedge clk);
    endtask

    task automatic t_full_sweep();
        for (int c = 0; c < (1 << P); c++) step(1'b1, c);
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);
    endtask

    task automatic t_mirror_pairs();
        int a;
        int b;
        for (int i = 0; i < 6; i++) begin
            int j;
            j = (i * 197) % DEPTH;
            single(DEPTH + j, a);
            single(DEPTH - 1 - j, b);
            chk(a == b, "R4 mirror pair", a, b);
            chk(a == ref_amp(DEPTH - 1 - j), "R4 mirror value", a, ref_amp(DEPTH - 1 - j));
        end
    endtask

    task automatic t_negation_pairs();
        int a;
        int b;
        for (int i = 0; i < 6; i++) begin
            int c;
            c = (i * 331 + 5) % (1 << (P - 1));
            single(c, a);
            single(c + (1 << (P - 1)), b);
            chk(b == -a, "R5 half-period negation", b, -a);
        end
    endtask

    task automatic t_idle_hold();
        int held;
        single(DEPTH / 3, held);
        for (int i = 0; i < 6; i++) begin
            phase_i = P'(i * 613 + 7);
            phase_valid_i = 1'b0;
            @(negedge clk);
            chk(int'(amp_o) == held, "R7 held while idle", int'(amp_o), held);
            chk(amp_valid_o == 1'b0, "R7 no valid while idle", int'(amp_valid_o), 0);
        end
    endtask

    task automatic t_reset_midstream();
        phase_valid_i = 1'b1;
        phase_i = P'(DEPTH / 2);
        @(negedge clk);
        phase_i = P'(DEPTH / 2 + 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(amp_valid_o == 1'b0, "R1 valid cleared", int'(amp_valid_o), 0);
        chk(int'(amp_o) == 0, "R1 amp cleared", int'(amp_o), 0);
        phase_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(amp_valid_o == 1'b0, "R1 nothing left after reset", int'(amp_valid_o), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full_sweep();
        t_mirror_pairs();
        t_negation_pairs();
        t_idle_hold();
        t_reset_midstream();
        finish_run();
    end

endmodule